// File: doc/BRIEF.md
# Video mode geometry validator

This block turns a set of display mode registers into the geometry a scanout engine needs: a pixel format code, the bytes per pixel, the visible width and height, the line stride in bytes, the byte offset of the first displayed pixel, and the byte size of the displayed area. It also decides whether the mode can be shown at all. A mode is rejected if it is switched off, if its colour depth is not supported, if it is smaller than the minimum side length, or if it does not fit inside the framebuffer memory.

The evaluation happens once per clock. The verdict appears on `mode_valid` one cycle after the inputs. The geometry outputs hold the last valid mode that was accepted. When a new valid mode differs from the held one in any field, the block takes it in and raises `mode_changed` for exactly one cycle. A consumer can use that pulse to rebuild its view of the surface.

Top module: `mode_geom_check`

## Requirements
- R1: When bit 0 of `cfg_enable` is 0 the mode is invalid, whatever the other inputs are.
- R2: A depth of 16 gives format code 1 (RGB 5-6-5) with 2 bytes per pixel. The byte-order flag has no effect on it, so toggling the flag in this depth produces no pulse and leaves the code at 1.
- R3: A depth of 32 gives 4 bytes per pixel. The format code is 2 (padded 8-8-8, little-endian) when `fb_big_endian` is 0 and 3 (the big-endian variant) when it is 1.
- R4: Any depth other than 16 or 32 makes the mode invalid.
- R5: The stride is the larger of `cfg_vwidth` and `cfg_xres`, multiplied by the bytes per pixel.
- R6: The size is the stride multiplied by `cfg_yres`.
- R7: The start offset is `cfg_xoff` times the bytes per pixel plus `cfg_yoff` times the stride, computed at 64-bit width.
- R8: A width or height below 64 makes the mode invalid. Exactly 64 is accepted.
- R9: If offset plus size is greater than `fb_mem_bytes`, the mode is invalid. An exact fit is valid.
- R10: `mode_valid` reflects the inputs sampled at the previous rising clock edge.
- R11: When a valid mode differs in any field from the held one, the geometry outputs take the new values and `mode_changed` is high for exactly that one cycle.
- R12: An invalid mode, or a valid mode equal to the held one, leaves the geometry outputs unchanged and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 16 | Enable register; bit 0 switches the mode on |
| cfg_depth | input | 16 | Colour depth in bits per pixel |
| cfg_xres | input | 16 | Visible width in pixels |
| cfg_yres | input | 16 | Visible height in lines |
| cfg_vwidth | input | 16 | Requested virtual line width in pixels |
| cfg_xoff | input | 16 | Horizontal panning offset in pixels |
| cfg_yoff | input | 16 | Vertical panning offset in lines |
| fb_big_endian | input | 1 | Byte order of 32-bit pixels (1 = big-endian) |
| fb_mem_bytes | input | 64 | Framebuffer memory size in bytes |
| mode_valid | output | 1 | Verdict on the inputs of the previous edge |
| mode_changed | output | 1 | One-cycle pulse when a new valid mode is taken |
| pix_fmt | output | 2 | Held format code (0 none, 1 RGB565, 2 XRGB LE, 3 XRGB BE) |
| pix_bytes | output | 3 | Held bytes per pixel |
| scan_width | output | 16 | Held width |
| scan_height | output | 16 | Held height |
| scan_stride | output | 32 | Held stride in bytes |
| scan_offset | output | 64 | Held start offset in bytes |
| scan_size | output | 64 | Held displayed size in bytes |

## Verification
The hardest case to reach is the memory-fit boundary, where offset plus size equals the memory size or exceeds it by one byte. Random register values almost never land on that exact byte count. To reach it, the stimulus first computes the end address of the random mode it has drawn, then sets the memory size to that end address or to one less. Repeated and byte-order-only changes are injected on purpose, so the case where a valid mode is seen again without a pulse is exercised as well.

// File: rtl/mgv_pkg.sv
package mgv_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned BYTES_W  = 3;
  localparam int unsigned STRIDE_W = 32;
  localparam int unsigned SPAN_W   = 64;
  localparam int unsigned EN_BIT   = 0;

  typedef enum logic [1:0] {
    PF_NONE    = 2'd0,
    PF_RGB565  = 2'd1,
    PF_XRGB_LE = 2'd2,
    PF_XRGB_BE = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    pix_fmt_e              fmt;
    logic [BYTES_W-1:0]    bytes;
    logic [REG_W-1:0]      width;
    logic [REG_W-1:0]      height;
    logic [STRIDE_W-1:0]   stride;
    logic [SPAN_W-1:0]     offset;
    logic [SPAN_W-1:0]     size;
  } geom_t;
endpackage

// File: rtl/mgv_depth_map.sv
module mgv_depth_map
  import mgv_pkg::*;
(
  input  logic [REG_W-1:0]   depth,
  input  logic               big_endian,
  output pix_fmt_e           fmt,
  output logic [BYTES_W-1:0] bytes,
  output logic               depth_ok
);
  always_comb begin
    fmt      = PF_NONE;
    bytes    = '0;
    depth_ok = 1'b0;
    case (depth)
      REG_W'(16): begin
        fmt      = PF_RGB565;
        bytes    = BYTES_W'(2);
        depth_ok = 1'b1;
      end
      REG_W'(32): begin
        fmt      = big_endian ? PF_XRGB_BE : PF_XRGB_LE;
        bytes    = BYTES_W'(4);
        depth_ok = 1'b1;
      end
      default: begin
        fmt      = PF_NONE;
        bytes    = '0;
        depth_ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mgv_geom_calc.sv
module mgv_geom_calc
  import mgv_pkg::*;
(
  input  logic [REG_W-1:0]    xres,
  input  logic [REG_W-1:0]    yres,
  input  logic [REG_W-1:0]    vwidth,
  input  logic [REG_W-1:0]    xoff,
  input  logic [REG_W-1:0]    yoff,
  input  logic [BYTES_W-1:0]  bytes,
  output logic [STRIDE_W-1:0] stride,
  output logic [SPAN_W-1:0]   offset,
  output logic [SPAN_W-1:0]   size
);
  logic [REG_W-1:0]  eff_width;
  logic [SPAN_W-1:0] stride_wide;
  logic [SPAN_W-1:0] pan_x;
  logic [SPAN_W-1:0] pan_y;

  always_comb begin
    eff_width   = (vwidth < xres) ? xres : vwidth;
    stride      = STRIDE_W'(eff_width) * STRIDE_W'(bytes);
    stride_wide = SPAN_W'(stride);
    size        = stride_wide * SPAN_W'(yres);
    pan_x       = SPAN_W'(xoff) * SPAN_W'(bytes);
    pan_y       = SPAN_W'(yoff) * stride_wide;
    offset      = pan_x + pan_y;
  end
endmodule

// File: rtl/mgv_fit_check.sv
module mgv_fit_check
  import mgv_pkg::*;
#(
  parameter int unsigned MIN_SIDE = 64
) (
  input  logic              enabled,
  input  logic              depth_ok,
  input  logic [REG_W-1:0]  width,
  input  logic [REG_W-1:0]  height,
  input  logic [SPAN_W-1:0] offset,
  input  logic [SPAN_W-1:0] size,
  input  logic [SPAN_W-1:0] mem_bytes,
  output logic              mode_ok
);
  localparam logic [REG_W-1:0] SIDE_MIN = REG_W'(MIN_SIDE);

  logic [SPAN_W-1:0] end_addr;
  logic              big_enough;
  logic              fits;

  always_comb begin
    end_addr   = offset + size;
    big_enough = (width >= SIDE_MIN) && (height >= SIDE_MIN);
    fits       = (end_addr <= mem_bytes);
    mode_ok    = enabled && depth_ok && big_enough && fits;
  end
endmodule

// File: rtl/mode_geom_check.sv
module mode_geom_check
  import mgv_pkg::*;
#(
  parameter int unsigned MIN_SIDE = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_W-1:0]    cfg_enable,
  input  logic [REG_W-1:0]    cfg_depth,
  input  logic [REG_W-1:0]    cfg_xres,
  input  logic [REG_W-1:0]    cfg_yres,
  input  logic [REG_W-1:0]    cfg_vwidth,
  input  logic [REG_W-1:0]    cfg_xoff,
  input  logic [REG_W-1:0]    cfg_yoff,
  input  logic                fb_big_endian,
  input  logic [SPAN_W-1:0]   fb_mem_bytes,
  output logic                mode_valid,
  output logic                mode_changed,
  output logic [1:0]          pix_fmt,
  output logic [BYTES_W-1:0]  pix_bytes,
  output logic [REG_W-1:0]    scan_width,
  output logic [REG_W-1:0]    scan_height,
  output logic [STRIDE_W-1:0] scan_stride,
  output logic [SPAN_W-1:0]   scan_offset,
  output logic [SPAN_W-1:0]   scan_size
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // candidate geometry
  pix_fmt_e            cand_fmt;
  logic [BYTES_W-1:0]  cand_bytes;
  logic                depth_ok;
  logic [STRIDE_W-1:0] cand_stride;
  logic [SPAN_W-1:0]   cand_offset;
  logic [SPAN_W-1:0]   cand_size;
  logic                cand_ok;

  mgv_depth_map u_depth (
    .depth      (cfg_depth),
    .big_endian (fb_big_endian),
    .fmt        (cand_fmt),
    .bytes      (cand_bytes),
    .depth_ok   (depth_ok)
  );

  mgv_geom_calc u_calc (
    .xres   (cfg_xres),
    .yres   (cfg_yres),
    .vwidth (cfg_vwidth),
    .xoff   (cfg_xoff),
    .yoff   (cfg_yoff),
    .bytes  (cand_bytes),
    .stride (cand_stride),
    .offset (cand_offset),
    .size   (cand_size)
  );

  mgv_fit_check #(.MIN_SIDE(MIN_SIDE)) u_fit (
    .enabled   (cfg_enable[EN_BIT]),
    .depth_ok  (depth_ok),
    .width     (cfg_xres),
    .height    (cfg_yres),
    .offset    (cand_offset),
    .size      (cand_size),
    .mem_bytes (fb_mem_bytes),
    .mode_ok   (cand_ok)
  );

  // next state
  geom_t cand_g;
  geom_t held_q, held_d;
  logic  latch_en;
  logic  chg_d, chg_q;
  logic  valid_d, valid_q;

  always_comb begin
    cand_g.fmt    = cand_fmt;
    cand_g.bytes  = cand_bytes;
    cand_g.width  = cfg_xres;
    cand_g.height = cfg_yres;
    cand_g.stride = cand_stride;
    cand_g.offset = cand_offset;
    cand_g.size   = cand_size;
    latch_en      = cand_ok && (cand_g != held_q);
    held_d        = held_q;
    if (latch_en) held_d = cand_g;
    chg_d         = latch_en;
    valid_d       = cand_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      held_q  <= '0;
      chg_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (latch_en) held_q <= held_d;
      chg_q   <= chg_d;
      valid_q <= valid_d;
    end
  end

  assign mode_valid   = valid_q;
  assign mode_changed = chg_q;
  assign pix_fmt      = held_q.fmt;
  assign pix_bytes    = held_q.bytes;
  assign scan_width   = held_q.width;
  assign scan_height  = held_q.height;
  assign scan_stride  = held_q.stride;
  assign scan_offset  = held_q.offset;
  assign scan_size    = held_q.size;
endmodule

// File: rtl/mgv_checker.sv
module mgv_checker
  import mgv_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [SPAN_W-1:0]   fb_mem_bytes,
  input logic                mode_valid,
  input logic                mode_changed,
  input logic [1:0]          pix_fmt,
  input logic [BYTES_W-1:0]  pix_bytes,
  input logic [REG_W-1:0]    scan_width,
  input logic [REG_W-1:0]    scan_height,
  input logic [STRIDE_W-1:0] scan_stride,
  input logic [SPAN_W-1:0]   scan_offset,
  input logic [SPAN_W-1:0]   scan_size
);
  AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> mode_valid); // R11

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_changed |-> ($stable(scan_stride) && $stable(scan_offset) && $stable(scan_size)
                       && $stable(scan_width) && $stable(scan_height) && $stable(pix_fmt))); // R12

  AST_MIN_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> (scan_width >= REG_W'(64) && scan_height >= REG_W'(64))); // R8

  AST_FITS_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> (scan_offset + scan_size <= $past(fb_mem_bytes))); // R9

  AST_STRIDE_COVERS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> (SPAN_W'(scan_stride) >= SPAN_W'(scan_width) * SPAN_W'(pix_bytes))); // R5

  AST_FMT_BYTES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_changed |-> ((pix_fmt == 2'd1) == (pix_bytes == BYTES_W'(2)))); // R2
endmodule

bind mode_geom_check mgv_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fb_mem_bytes (fb_mem_bytes),
  .mode_valid   (mode_valid),
  .mode_changed (mode_changed),
  .pix_fmt      (pix_fmt),
  .pix_bytes    (pix_bytes),
  .scan_width   (scan_width),
  .scan_height  (scan_height),
  .scan_stride  (scan_stride),
  .scan_offset  (scan_offset),
  .scan_size    (scan_size)
);

// File: tb/sim_mode_geom_check.sv
module sim_mode_geom_check;
  logic        clk;
  logic        rst_n;
  logic [15:0] cfg_enable, cfg_depth, cfg_xres, cfg_yres, cfg_vwidth, cfg_xoff, cfg_yoff;
  logic        fb_big_endian;
  logic [63:0] fb_mem_bytes;
  logic        mode_valid, mode_changed;
  logic [1:0]  pix_fmt;
  logic [2:0]  pix_bytes;
  logic [15:0] scan_width, scan_height;
  logic [31:0] scan_stride;
  logic [63:0] scan_offset, scan_size;

  int checks;
  int fails;
  bit done;

  // model of the held mode
  longint unsigned m_fmt, m_bytes, m_w, m_h, m_stride, m_off, m_size;
  // candidate computed by the model
  longint unsigned c_fmt, c_bytes, c_stride, c_off, c_size;
  bit              c_ok;
  string           c_tag;

  mode_geom_check u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_enable(cfg_enable), .cfg_depth(cfg_depth),
    .cfg_xres(cfg_xres), .cfg_yres(cfg_yres), .cfg_vwidth(cfg_vwidth),
    .cfg_xoff(cfg_xoff), .cfg_yoff(cfg_yoff),
    .fb_big_endian(fb_big_endian), .fb_mem_bytes(fb_mem_bytes),
    .mode_valid(mode_valid), .mode_changed(mode_changed),
    .pix_fmt(pix_fmt), .pix_bytes(pix_bytes),
    .scan_width(scan_width), .scan_height(scan_height),
    .scan_stride(scan_stride), .scan_offset(scan_offset), .scan_size(scan_size)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected geometry from the requirements
  task automatic model(input longint unsigned en, dep, xr, yr, vw, xo, yo, be, mem);
    longint unsigned eff;
    bit dok;
    dok = 1'b1;
    if (dep == 16) begin c_fmt = 1; c_bytes = 2; end                     // R2
    else if (dep == 32) begin c_fmt = (be != 0) ? 3 : 2; c_bytes = 4; end // R3
    else begin c_fmt = 0; c_bytes = 0; dok = 1'b0; end                    // R4
    eff      = (vw < xr) ? xr : vw;                                        // R5
    c_stride = eff * c_bytes;
    c_size   = c_stride * yr;                                              // R6
    c_off    = xo * c_bytes + yo * c_stride;                               // R7
    if (en[0] == 1'b0) begin c_ok = 0; c_tag = "R1"; end
    else if (!dok) begin c_ok = 0; c_tag = "R4"; end
    else if (xr < 64 || yr < 64) begin c_ok = 0; c_tag = "R8"; end
    else if (c_off + c_size > mem) begin c_ok = 0; c_tag = "R9"; end
    else begin c_ok = 1; c_tag = "R10"; end
  endtask

  task automatic step(input longint unsigned en, dep, xr, yr, vw, xo, yo, be, mem);
    bit diff;
    cfg_enable = 16'(en); cfg_depth = 16'(dep); cfg_xres = 16'(xr); cfg_yres = 16'(yr);
    cfg_vwidth = 16'(vw); cfg_xoff = 16'(xo); cfg_yoff = 16'(yo);
    fb_big_endian = be[0]; fb_mem_bytes = mem;
    model(en, dep, xr, yr, vw, xo, yo, be, mem);
    diff = (c_fmt != m_fmt) || (c_bytes != m_bytes) || (xr != m_w) || (yr != m_h)
        || (c_stride != m_stride) || (c_off != m_off) || (c_size != m_size);
    @(posedge clk);
    @(negedge clk);
    check(c_tag, mode_valid, c_ok);
    if (c_ok && diff) begin
      m_fmt = c_fmt; m_bytes = c_bytes; m_w = xr; m_h = yr;
      m_stride = c_stride; m_off = c_off; m_size = c_size;
      check("R11 pulse", mode_changed, 1);
    end else begin
      check("R12 no pulse", mode_changed, 0);
    end
    check("R2/R3 format", pix_fmt, m_fmt);
    check("R2/R3 bytes", pix_bytes, m_bytes);
    check("R11 width", scan_width, m_w);
    check("R11 height", scan_height, m_h);
    check("R5 stride", scan_stride, m_stride);
    check("R7 offset", scan_offset, m_off);
    check("R6 size", scan_size, m_size);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint unsigned mib;
    mib = 64'd1 << 20;
    checks = 0; fails = 0; done = 0;
    m_fmt = 0; m_bytes = 0; m_w = 0; m_h = 0; m_stride = 0; m_off = 0; m_size = 0;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    cfg_enable = 0; cfg_depth = 0; cfg_xres = 0; cfg_yres = 0; cfg_vwidth = 0;
    cfg_xoff = 0; cfg_yoff = 0; fb_big_endian = 0; fb_mem_bytes = 0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", mode_valid, 0);
    check("R12 reset pulse", mode_changed, 0);
    check("R11 reset width", scan_width, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    step(1, 32, 640, 480, 0, 0, 0, 0, 16*mib);        // R3 little-endian
    step(1, 32, 640, 480, 0, 0, 0, 0, 16*mib);        // R12 same mode again
    step(1, 32, 640, 480, 0, 0, 0, 1, 16*mib);        // R3 big-endian
    step(0, 32, 800, 600, 0, 0, 0, 0, 16*mib);        // R1 disabled
    step(1, 16, 800, 600, 1024, 3, 5, 0, 16*mib);     // R2, R5, R7
    step(1, 16, 800, 600, 1024, 3, 5, 1, 16*mib);     // R2 order ignored
    step(1, 24, 800, 600, 0, 0, 0, 0, 16*mib);        // R4
    step(1, 8, 800, 600, 0, 0, 0, 0, 16*mib);         // R4
    step(1, 32, 64, 64, 0, 0, 0, 0, 16*mib);          // R8 edge accepted
    step(1, 32, 63, 64, 0, 0, 0, 0, 16*mib);          // R8
    step(1, 32, 64, 63, 0, 0, 0, 0, 16*mib);          // R8
    step(1, 32, 100, 100, 50, 0, 0, 0, 40000);        // R9 exact fit, R5 clamp
    step(1, 32, 100, 100, 50, 0, 0, 0, 39999);        // R9 one short
    step(1, 32, 65535, 65535, 65535, 65535, 65535, 0, 64'hFFFF_FFFF_FFFF); // R7 wide

    for (int i = 0; i < 300; i++) begin
      longint unsigned en, dep, xr, yr, vw, xo, yo, be, mem, sel;
      en  = ($urandom % 8 == 0) ? 0 : 1;
      sel = $urandom % 6;
      dep = (sel < 2) ? 16 : (sel < 4) ? 32 : (sel == 4) ? 24 : 15;
      xr  = 40 + $urandom % 1200;
      yr  = 40 + $urandom % 900;
      vw  = $urandom % 1400;
      xo  = $urandom % 128;
      yo  = $urandom % 128;
      be  = $urandom % 2;
      model(en, dep, xr, yr, vw, xo, yo, be, 0);
      sel = $urandom % 4;
      mem = (sel == 0) ? 4*mib : (sel == 1) ? c_off + c_size :
            (sel == 2) ? ((c_off + c_size > 0) ? c_off + c_size - 1 : 0) : 16*mib;
      step(en, dep, xr, yr, vw, xo, yo, be, mem);
      if ($urandom % 5 == 0) step(en, dep, xr, yr, vw, xo, yo, be, mem); // R12 repeat
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule